// File: doc/BRIEF.md
# Bit-Serial Fractional Add/Subtract Unit

This unit performs two's complement addition and subtraction on fractional words that arrive one binary digit per clock. Each 32-bit word carries 30 value bits with the binary point just after the sign bit, so every operand and result lies in the range -1 up to just under +1. Above the value bits sit a tag bit that marks the word as a number and one spare bit. Two operand streams enter side by side, least significant digit first. The result stream leaves one clock behind them.

The unit remembers the sign and the overflow condition of the most recent add or subtract word. A select word uses that stored sign to pass one of its two operands to the result stream unchanged. A controlling sequencer can build conditional transfers from this without a branch inside the arithmetic path. Framing comes from two strobes that mark the first and last digit of a word. A valid qualifier lets the stream pause at any digit.

Top module: `serial_fraction_alu`

## Requirements
- R1: A digit is consumed only in a cycle with `in_valid` high. Within a word, digit positions 0..29 are value bits, least significant first, and position 29 is the sign. Position 30 is the tag and position 31 is spare. `word_first` marks position 0 and `word_last` marks position 31. Cycles with `in_valid` low are ignored and may fall anywhere inside a word.
- R2: With op code 2'b00 (add), or the reserved code 2'b11 that acts as add, result positions 0..29 equal (A + B) mod 2^30.
- R3: With op code 2'b01 (subtract), result positions 0..29 equal (A - B) mod 2^30. No carry or borrow passes from one word into the next.
- R4: At the end of an add or subtract word, `ovf_flag` becomes 1 exactly when the true signed result lies outside [-2^29, 2^29) in integer units. This is the case where the carry into the sign position differs from the carry out of it.
- R5: With op code 2'b10 (select), result positions 0..29 equal operand B when `last_sign` is 1 and operand A when it is 0.
- R6: Every result word carries 0 (number) in position 30 and 0 in position 31, whatever the operands hold there.
- R7: `last_sign` takes the result's position-29 bit, and `ovf_flag` takes its new value, only at the accepted `word_last` digit of an add or subtract word. Both hold through select words and inside words.
- R8: Each accepted digit produces its result digit on `res_bit` with `res_valid` high in the next cycle. `res_valid` is low in every other cycle.
- R9: The op code is sampled only with the accepted `word_first` digit. Changes to `op` later in the word have no effect.
- R10: The synchronous active-high reset clears `res_valid`, `last_sign` and `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the digit presented this cycle |
| word_first | input | 1 | Marks digit position 0 of a word |
| word_last | input | 1 | Marks digit position 31 of a word |
| op | input | 2 | Operation code, sampled with word_first |
| a_bit | input | 1 | Operand A digit |
| b_bit | input | 1 | Operand B digit |
| res_bit | output | 1 | Result digit, registered |
| res_valid | output | 1 | Result digit qualifier |
| last_sign | output | 1 | Sign of the latest add/subtract result |
| ovf_flag | output | 1 | Overflow of the latest add/subtract result |

## Verification
The bound checker watches, on every cycle, the one-cycle result latency and its qualifier, the forced tag and spare digits, select words copying the operand chosen by the stored sign, and the flags holding outside the closing digit of an arithmetic word. The arithmetic itself needs the bench's scenarios and reference model to show: carry chains across the full width, borrow in subtraction, positive and negative overflow, isolation of carries between back-to-back words, pauses inside a word, and an op code that changes after the first digit.

// File: rtl/serial_fraction_alu_pkg.sv
package serial_fraction_alu_pkg;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_SEL = 2'b10,
    ALU_RSV = 2'b11   // reserved, behaves as add
  } alu_op_e;

  function automatic logic op_is_arith(input alu_op_e o);
    return (o != ALU_SEL);
  endfunction

  function automatic logic op_is_sub(input alu_op_e o);
    return (o == ALU_SUB);
  endfunction

endpackage

// File: rtl/sfa_digit_seq.sv
// Tracks the digit position within a word and latches the op code on the
// first accepted digit.
module sfa_digit_seq
  import serial_fraction_alu_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             word_first,
  input  logic [1:0]       op,
  output logic [CNT_W-1:0] pos,
  output alu_op_e          cur_op
);

  logic [CNT_W-1:0] cnt_q;
  alu_op_e          op_q;

  always_comb begin
    pos    = word_first ? '0 : cnt_q;
    cur_op = word_first ? alu_op_e'(op) : op_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      op_q  <= ALU_ADD;
    end else if (in_valid) begin
      cnt_q <= pos + CNT_W'(1);
      op_q  <= cur_op;
    end
  end

endmodule

// File: rtl/sfa_serial_adder.sv
// One full-adder slice with a carry flip-flop. The carry is cleared (add)
// or preset (subtract) on the first digit so no word inherits a carry.
module sfa_serial_adder (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic word_first,
  input  logic sub,
  input  logic a,
  input  logic b,
  output logic sum,
  output logic cin,
  output logic cout
);

  logic carry_q;
  logic bx;

  always_comb begin
    bx   = b ^ sub;
    cin  = word_first ? sub : carry_q;
    sum  = a ^ bx ^ cin;
    cout = (a & bx) | (cin & (a ^ bx));
  end

  always_ff @(posedge clk) begin
    if (rst)           carry_q <= 1'b0;
    else if (in_valid) carry_q <= cout;
  end

endmodule

// File: rtl/sfa_flags.sv
// Captures sign and overflow at the sign position and commits them at
// the last digit of an arithmetic word.
module sfa_flags #(
  parameter int WORD_W = 32,
  parameter int VAL_W  = 30,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             word_last,
  input  logic             arith,
  input  logic [CNT_W-1:0] pos,
  input  logic             sum,
  input  logic             cin,
  input  logic             cout,
  output logic             sign_q,
  output logic             ovf_q
);

  localparam logic [CNT_W-1:0] SIGN_P = CNT_W'(VAL_W - 1);

  logic pend_sign, pend_ovf;
  logic at_sign;
  logic new_sign, new_ovf;

  always_comb begin
    at_sign  = (pos == SIGN_P);
    new_sign = at_sign ? sum : pend_sign;
    new_ovf  = at_sign ? (cin ^ cout) : pend_ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_sign <= 1'b0;
      pend_ovf  <= 1'b0;
    end else if (in_valid && at_sign) begin
      pend_sign <= sum;
      pend_ovf  <= cin ^ cout;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sign_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (in_valid && word_last && arith) begin
      sign_q <= new_sign;
      ovf_q  <= new_ovf;
    end
  end

endmodule

// File: rtl/serial_fraction_alu.sv
module serial_fraction_alu
  import serial_fraction_alu_pkg::*;
#(
  parameter int   WORD_W  = 32,
  parameter int   VAL_W   = 30,
  parameter logic NUM_TAG = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       word_first,
  input  logic       word_last,
  input  logic [1:0] op,
  input  logic       a_bit,
  input  logic       b_bit,
  output logic       res_bit,
  output logic       res_valid,
  output logic       last_sign,
  output logic       ovf_flag
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] TAG_P = CNT_W'(VAL_W);

  logic [CNT_W-1:0] pos;
  alu_op_e          cur_op;
  logic             sum, cin, cout;
  logic             nxt_bit;
  logic             val_bit;

  sfa_digit_seq #(.WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .word_first(word_first),
    .op(op), .pos(pos), .cur_op(cur_op)
  );

  sfa_serial_adder u_add (
    .clk(clk), .rst(rst), .in_valid(in_valid), .word_first(word_first),
    .sub(op_is_sub(cur_op)), .a(a_bit), .b(b_bit),
    .sum(sum), .cin(cin), .cout(cout)
  );

  sfa_flags #(.WORD_W(WORD_W), .VAL_W(VAL_W)) u_flags (
    .clk(clk), .rst(rst), .in_valid(in_valid), .word_last(word_last),
    .arith(op_is_arith(cur_op)), .pos(pos), .sum(sum), .cin(cin),
    .cout(cout), .sign_q(last_sign), .ovf_q(ovf_flag)
  );

  always_comb begin
    val_bit = (cur_op == ALU_SEL) ? (last_sign ? b_bit : a_bit) : sum;
  end

  // Positions above the tag exist only when the word is wider than
  // value + tag; the generate picks the matching digit mux.
  generate
    if (WORD_W > VAL_W + 1) begin : g_spare
      always_comb begin
        if (pos < TAG_P)       nxt_bit = val_bit;
        else if (pos == TAG_P) nxt_bit = NUM_TAG;
        else                   nxt_bit = 1'b0;
      end
    end else begin : g_nospare
      always_comb begin
        nxt_bit = (pos < TAG_P) ? val_bit : NUM_TAG;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_bit   <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res_bit <= nxt_bit;
    end
  end

endmodule

// File: rtl/serial_fraction_alu_chk.sv
module serial_fraction_alu_chk #(
  parameter int   WORD_W  = 32,
  parameter int   VAL_W   = 30,
  parameter logic NUM_TAG = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       word_first,
  input logic       word_last,
  input logic [1:0] op,
  input logic       a_bit,
  input logic       b_bit,
  input logic       res_bit,
  input logic       res_valid,
  input logic       last_sign,
  input logic       ovf_flag
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] TAG_P = CNT_W'(VAL_W);

  logic [CNT_W-1:0] c_cnt;
  logic [1:0]       c_op;
  logic [CNT_W-1:0] c_pos;
  logic [1:0]       c_cur;

  assign c_pos = word_first ? '0 : c_cnt;
  assign c_cur = word_first ? op : c_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_cnt <= '0;
      c_op  <= 2'b00;
    end else if (in_valid) begin
      c_cnt <= c_pos + CNT_W'(1);
      c_op  <= c_cur;
    end
  end

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);

  assert_tag_number_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && c_pos == TAG_P) |=> (res_bit == NUM_TAG));

  assert_spare_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && c_pos > TAG_P) |=> !res_bit);

  assert_select_copies_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && c_cur == 2'b10 && c_pos < TAG_P)
      |=> (res_bit == $past(last_sign ? b_bit : a_bit)));

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && word_last && c_cur != 2'b10)
      |=> ($stable(last_sign) && $stable(ovf_flag)));

endmodule

bind serial_fraction_alu serial_fraction_alu_chk #(
  .WORD_W(WORD_W), .VAL_W(VAL_W), .NUM_TAG(NUM_TAG)
) u_chk (.*);

// File: tb/test_serial_fraction_alu.sv
module test_serial_fraction_alu;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, word_first = 1'b0, word_last = 1'b0;
  logic [1:0] op = 2'b00;
  logic       a_bit = 1'b0, b_bit = 1'b0;
  logic       res_bit, res_valid, last_sign, ovf_flag;

  int   n_vec = 0;
  int   n_bad = 0;
  logic exp_sign = 1'b0;
  logic exp_ovf  = 1'b0;
  logic  exp_q[$];
  string req_q[$];

  always #5 clk = ~clk;

  serial_fraction_alu i_serial_fraction_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .word_first(word_first),
    .word_last(word_last), .op(op), .a_bit(a_bit), .b_bit(b_bit),
    .res_bit(res_bit), .res_valid(res_valid), .last_sign(last_sign),
    .ovf_flag(ovf_flag)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Output monitor: one comparison per result digit, plus a check that
  // no result appears without a pending expected digit (R8).
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) chk(1'b1, 1'b0, "R8 unexpected res_valid");
      else begin
        string r;
        logic  e;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(res_bit, e, r);
      end
    end
  end

  // Sends one word; gap_every > 0 inserts an idle cycle with garbage
  // inputs before every gap_every-th digit (R1). The op input carries
  // garbage after the first digit (R9).
  task automatic send_word(input logic [1:0] opc, input int av, input int bv,
                           input int gap_every);
    logic [29:0] aw, bw, rv;
    longint      r;
    logic        ovf;
    logic        arith;
    string       base;
    aw    = av[29:0];
    bw    = bv[29:0];
    arith = (opc != 2'b10);
    if (opc == 2'b01) r = longint'(av) - longint'(bv);
    else              r = longint'(av) + longint'(bv);
    ovf = (r < -(64'sd1 << 29)) || (r >= (64'sd1 << 29));
    if (arith) rv = r[29:0];
    else       rv = exp_sign ? bw : aw;
    base = (opc == 2'b10) ? "R5" : ((opc == 2'b01) ? "R3" : "R2");
    for (int i = 0; i < 32; i++) begin
      if (i < 30) begin
        exp_q.push_back(rv[i]);
        req_q.push_back($sformatf("%s R1 R8 R9 digit %0d", base, i));
      end else begin
        exp_q.push_back(1'b0);
        req_q.push_back($sformatf("R6 digit %0d", i));
      end
    end
    for (int i = 0; i < 32; i++) begin
      if (gap_every > 0 && (i % gap_every) == gap_every - 1) begin
        @(negedge clk);
        in_valid   = 1'b0;
        word_first = 1'($urandom);
        word_last  = 1'($urandom);
        op         = 2'($urandom);
        a_bit      = 1'($urandom);
        b_bit      = 1'($urandom);
      end
      @(negedge clk);
      in_valid   = 1'b1;
      word_first = (i == 0);
      word_last  = (i == 31);
      op         = (i == 0) ? opc : 2'($urandom);
      a_bit      = (i < 30) ? aw[i] : 1'($urandom);
      b_bit      = (i < 30) ? bw[i] : 1'($urandom);
    end
    @(negedge clk);
    in_valid   = 1'b0;
    word_first = 1'b0;
    word_last  = 1'b0;
    if (arith) begin
      exp_sign = rv[29];
      exp_ovf  = ovf;
    end
    chk(last_sign, exp_sign, "R7 last_sign");
    chk(ovf_flag, exp_ovf, "R4 ovf_flag");
  endtask

  localparam int MAXP = (1 << 29) - 1;
  localparam int MINN = -(1 << 29);

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(res_valid, 1'b0, "R10 res_valid after reset");
    chk(last_sign, 1'b0, "R10 last_sign after reset");
    chk(ovf_flag,  1'b0, "R10 ovf_flag after reset");

    send_word(2'b00, 5, 7, 0);              // R2 simple add
    send_word(2'b00, -1, 1, 0);             // R2 full carry chain
    send_word(2'b00, -1, -1, 0);            // carry out of top
    send_word(2'b00, 0, 0, 0);              // R3 isolation: no carry leak
    send_word(2'b00, MAXP, 1, 0);           // R4 positive overflow
    send_word(2'b10, 111, 222, 0);          // R5 sign 1 picks B, R7 hold
    send_word(2'b00, MINN, -1, 0);          // R4 negative overflow
    send_word(2'b01, 3, 10, 0);             // R3 borrow, negative result
    send_word(2'b10, 333, 444, 3);          // R5 sign 1, with pauses
    send_word(2'b01, 10, 3, 5);             // R3 positive, pauses (R1)
    send_word(2'b10, 555, 666, 0);          // R5 sign 0 picks A
    send_word(2'b01, MINN, 1, 0);           // R4 subtract overflow
    send_word(2'b01, 0, MINN, 0);           // R4 negate min overflows
    send_word(2'b11, 20, -30, 2);           // R2 reserved code adds
    send_word(2'b01, 0, 0, 0);              // R3 preset carry only
    for (int k = 0; k < 40; k++) begin
      send_word(2'($urandom_range(0, 3)),
                int'($urandom_range(0, MAXP)) - int'($urandom_range(0, MAXP)) / 2,
                int'($urandom_range(0, MAXP)) - int'($urandom_range(0, MAXP)),
                (k % 4 == 0) ? 7 : 0);
    end
    repeat (3) @(negedge clk);
    chk(1'(exp_q.size() != 0), 1'b0, "R8 missing result digits");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule